// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block raises a periodic tick interrupt from a slow reference strobe. The strobe, one clock-wide pulse per period of a 32768 Hz reference, is divided by a power of two chosen by a 4-bit rate field. Each divided strobe is one counting step for a down-counter. When the counter runs out, a sticky pending flag is set, the interrupt line goes high and the counter reloads by itself from a programmable period value.

Software reaches the block through a small register port: one write port (enable, address, data) and one combinational read port. There are four word registers: control, period, pending and live count. The timer runs only while both the global enable and the tick enable in the control word are set. It is started only by a 0-to-1 change of the tick enable.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset all four registers read zero and `tick_irq_o` is low.
- R2: A write to the period register (address 1) is ignored when its data value is 2 or less, or does not fit in CNT_W bits. Any other value is stored. The period resets to 0.
- R3: A control write (address 0) starts the timer when it sets bit 0 (global enable) and bit 8 (tick enable), bit 8 was previously 0, and the stored period is nonzero. From the next cycle the count equals the period.
- R4: While running, the count drops by one for every 2^N reference strobes, where N is control bits 7:4. The prescaler starts afresh at each start.
- R5: A counting step taken with count 1 is an expiry. It sets pending bit 0 (address 2), drives `tick_irq_o` high and reloads the count with the period, so ticks come every "period" steps.
- R6: A pending-register write with data bit 0 set clears the pending flag and the interrupt line, and a write with bit 0 clear has no effect. An expiry in the same cycle wins over the clear.
- R7: A control write that clears bit 0 or bit 8 stops the timer from the next cycle, and the count then holds its value.
- R8: Setting the global enable again while the tick enable stays 1 does not restart a stopped timer.
- R9: Changing the rate field while running keeps the count and the prescaler position. The new division applies from the next reference strobe.
- R10: Reads are combinational. Address 0 returns bits 0, 7:4 and 8 as written, with all other bits zero. Address 1 returns the period, address 2 the pending flag in bit 0, and address 3 the live count.
- R11: Reference strobes have no effect while the timer is stopped, and no expiry occurs then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | One-cycle strobe at the reference rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Write address |
| wdata_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data for `rd_addr_i` |
| tick_irq_o | output | 1 | Tick interrupt, high while pending |

## Verification
Directed sequences first use division 1, so every strobe is a step and the count values show the exact period and the moment of reload. Division 4 then shows that a step needs a whole group of strobes, and a rate change in mid-group shows that the count is kept. Stop, re-enable and toggle patterns separate the rising-edge start rule from a plain level enable. A clear in the same cycle as an expiry shows the priority. A seeded random stream of writes, strobes and reads is then compared every cycle with a bench model. It mixes rejected and accepted period values and divisions of 1 to 8.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_PEND   = 2'd2,
    REG_COUNT  = 2'd3
  } tick_reg_e;

  localparam int CTRL_GLB_BIT = 0;
  localparam int CTRL_SEL_LSB = 4;
  localparam int CTRL_TEN_BIT = 8;
  localparam int PEND_BIT     = 0;
  localparam int PERIOD_FLOOR = 2;
endpackage

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              glb_en,
  output logic              tick_en,
  output logic [SEL_W-1:0]  rate_sel,
  output logic [CNT_W-1:0]  period,
  output logic              running,
  output logic              start,
  output logic              pending
);
  logic wr_ctrl, wr_period, wr_pend;
  logic new_glb, new_ten, halt, period_ok;

  assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
  assign wr_period = wr_en && (wr_addr == REG_PERIOD);
  assign wr_pend   = wr_en && (wr_addr == REG_PEND);

  assign new_glb = wdata[CTRL_GLB_BIT];
  assign new_ten = wdata[CTRL_TEN_BIT];

  // start only on a rising tick enable with the global enable set
  assign start = wr_ctrl && new_glb && new_ten && !tick_en && (period != '0);
  assign halt  = wr_ctrl && !(new_glb && new_ten);

  assign period_ok = (wdata[DATA_W-1:CNT_W] == '0) &&
                     (wdata[CNT_W-1:0] > CNT_W'(PERIOD_FLOOR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      tick_en  <= 1'b0;
      rate_sel <= '0;
    end else if (wr_ctrl) begin
      glb_en   <= new_glb;
      tick_en  <= new_ten;
      rate_sel <= wdata[CTRL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      period <= '0;
    else if (wr_period && period_ok) period <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     running <= 1'b0;
    else if (start) running <= 1'b1;
    else if (halt)  running <= 1'b0;
  end

  // expiry has priority over a software clear
  always_ff @(posedge clk) begin
    if (!rst_n)                            pending <= 1'b0;
    else if (expire)                       pending <= 1'b1;
    else if (wr_pend && wdata[PEND_BIT])   pending <= 1'b0;
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             start,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             step
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [PRE_W-1:0] ONES = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // mask has rate_sel low bits set; all ones in those bits marks a group end
  assign mask = ONES >> (PRE_W - int'(rate_sel));
  assign step = running && ref_tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)                 pre_q <= '0;
    else if (start || !running) pre_q <= '0;
    else if (ref_tick)          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tick_downcount.sv
module tick_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = step && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (start)  count <= period;
    else if (expire) count <= period;
    else if (step)   count <= count - 1'b1;
  end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tick_irq_o
);
  logic             glb_w, ten_w, run_w, start_w, step_w, expire_w, pend_w;
  logic [SEL_W-1:0] sel_w;
  logic [CNT_W-1:0] period_w, count_w;

  tick_ctrl_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(addr_i),
    .wdata(wdata_i), .expire(expire_w), .glb_en(glb_w), .tick_en(ten_w),
    .rate_sel(sel_w), .period(period_w), .running(run_w),
    .start(start_w), .pending(pend_w)
  );

  tick_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .running(run_w), .start(start_w),
    .ref_tick(ref_tick_i), .rate_sel(sel_w), .step(step_w)
  );

  tick_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start_w), .step(step_w),
    .period(period_w), .count(count_w), .expire(expire_w)
  );

  assign tick_irq_o = pend_w;

  always_comb begin
    rd_data_o = '0;
    case (tick_reg_e'(rd_addr_i))
      REG_CTRL: begin
        rd_data_o[CTRL_GLB_BIT]            = glb_w;
        rd_data_o[CTRL_SEL_LSB +: SEL_W]   = sel_w;
        rd_data_o[CTRL_TEN_BIT]            = ten_w;
      end
      REG_PERIOD: rd_data_o = DATA_W'(period_w);
      REG_PEND:   rd_data_o[PEND_BIT] = pend_w;
      REG_COUNT:  rd_data_o = DATA_W'(count_w);
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             start,
  input logic             step,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period,
  input logic             pending,
  input logic             clr_wr
);
  logic at_end;
  assign at_end = step && (count == CNT_W'(1));

  assert_period_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) || (period > CNT_W'(2)));

  assert_run_needs_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (period != '0));

  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && count == $past(period)));

  assert_expiry_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> (pending && count == $past(period)));

  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !at_end) |=> !pending);

  assert_halt_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));

  assert_idle_no_expiry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !$rose(pending));
endmodule

bind periodic_tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(run_w), .start(start_w),
  .step(step_w), .count(count_w), .period(period_w), .pending(pend_w),
  .clr_wr(wr_en_i && (addr_i == 2'd2) && wdata_i[0])
);

// File: tb/test_periodic_tick_timer.sv
module test_periodic_tick_timer;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        addr = '0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  periodic_tick_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(4)) i_periodic_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .tick_irq_o(irq)
  );

  // ---- reference model built from the requirements ----
  logic             m_glb, m_ten, m_run, m_pend;
  logic [3:0]       m_sel;
  logic [CNT_W-1:0] m_period, m_cnt;
  int unsigned      m_refs;
  logic             m_step, m_start, m_stop, m_clear, m_ok;

  assign m_step  = m_run && ref_tick && (((m_refs + 1) % (32'd1 << m_sel)) == 0);
  assign m_start = wr_en && addr == 2'd0 && wdata[0] && wdata[8] && !m_ten && m_period != 0;
  assign m_stop  = wr_en && addr == 2'd0 && !(wdata[0] && wdata[8]);
  assign m_clear = wr_en && addr == 2'd2 && wdata[0];
  assign m_ok    = wdata > 32'd2 && wdata < 32'h0001_0000;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_glb <= 0; m_ten <= 0; m_run <= 0; m_pend <= 0;
      m_sel <= 0; m_period <= 0; m_cnt <= 0; m_refs <= 0;
    end else begin
      if (m_start || !m_run) m_refs <= 0;
      else if (ref_tick)     m_refs <= m_refs + 1;
      if (m_start)                   m_cnt <= m_period;
      else if (m_step && m_cnt == 1) m_cnt <= m_period;
      else if (m_step)               m_cnt <= m_cnt - 1'b1;
      if (m_step && m_cnt == 1) m_pend <= 1'b1;
      else if (m_clear)         m_pend <= 1'b0;
      if (m_start)     m_run <= 1'b1;
      else if (m_stop) m_run <= 1'b0;
      if (wr_en && addr == 2'd0) begin
        m_glb <= wdata[0]; m_ten <= wdata[8]; m_sel <= wdata[7:4];
      end
      if (wr_en && addr == 2'd1 && m_ok) m_period <= wdata[CNT_W-1:0];
    end
  end

  function automatic logic [DATA_W-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {23'd0, m_ten, m_sel, 3'd0, m_glb};
      2'd1:    return DATA_W'(m_period);
      2'd2:    return DATA_W'(m_pend);
      default: return DATA_W'(m_cnt);
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0:    return "R10";
      2'd1:    return "R2";
      2'd2:    return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_rd(input string req, input logic [1:0] a,
                        input logic [DATA_W-1:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  // one clock, then compare against the model at the falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check("R5", DATA_W'(irq), DATA_W'(m_pend));
    check(tag_of(rd_addr), rd_data, exp_read(rd_addr));
    wr_en = 1'b0;
    ref_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    cyc();
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      cyc();
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 4; a++) chk_rd("R1", 2'(a), '0);
    check("R1", DATA_W'(irq), '0);

    // R2 period filter
    wr(2'd1, 32'd2);          chk_rd("R2", 2'd1, 32'd0);
    wr(2'd1, 32'h0001_0005);  chk_rd("R2", 2'd1, 32'd0);
    wr(2'd1, 32'd5);          chk_rd("R2", 2'd1, 32'd5);
    wr(2'd1, 32'd1);          chk_rd("R2", 2'd1, 32'd5);

    // R3 start, R10 control read
    wr(2'd0, 32'h101);
    chk_rd("R3", 2'd3, 32'd5);
    chk_rd("R10", 2'd0, 32'h101);
    pulses(4);
    chk_rd("R4", 2'd3, 32'd1);
    chk_rd("R5", 2'd2, 32'd0);
    pulses(1);
    chk_rd("R5", 2'd2, 32'd1);
    chk_rd("R5", 2'd3, 32'd5);
    check("R5", DATA_W'(irq), 1);

    // R6 clearing
    wr(2'd2, 32'd0);  chk_rd("R6", 2'd2, 32'd1);
    wr(2'd2, 32'd1);  chk_rd("R6", 2'd2, 32'd0);
    check("R6", DATA_W'(irq), 0);
    pulses(4);
    addr = 2'd2; wdata = 32'd1; wr_en = 1'b1; ref_tick = 1'b1;
    cyc();
    chk_rd("R6", 2'd2, 32'd1);
    chk_rd("R5", 2'd3, 32'd5);
    wr(2'd2, 32'd1);

    // R7 / R11 stop via tick enable
    wr(2'd0, 32'h001);
    pulses(3);
    chk_rd("R7", 2'd3, 32'd5);
    chk_rd("R11", 2'd2, 32'd0);

    // R8 global re-enable does not restart
    wr(2'd0, 32'h101);
    pulses(2);
    chk_rd("R3", 2'd3, 32'd3);
    wr(2'd0, 32'h100);
    pulses(2);
    chk_rd("R7", 2'd3, 32'd3);
    wr(2'd0, 32'h101);
    pulses(3);
    chk_rd("R8", 2'd3, 32'd3);
    chk_rd("R8", 2'd2, 32'd0);

    // R4 division by four, R9 rate change mid-run
    wr(2'd0, 32'h001);
    wr(2'd0, 32'h121);
    chk_rd("R3", 2'd3, 32'd5);
    pulses(3);
    chk_rd("R4", 2'd3, 32'd5);
    pulses(1);
    chk_rd("R4", 2'd3, 32'd4);
    pulses(2);
    wr(2'd0, 32'h101);
    chk_rd("R9", 2'd3, 32'd4);
    pulses(1);
    chk_rd("R9", 2'd3, 32'd3);

    // R10 unused control bits read zero
    wr(2'd0, 32'hFFFF_FEF1);
    chk_rd("R10", 2'd0, 32'h0F1);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      ref_tick = 1'($urandom % 2);
      rd_addr  = 2'($urandom % 4);
      if ($urandom % 8 == 0) begin
        addr  = 2'($urandom % 4);
        wr_en = 1'b1;
        case (addr)
          2'd0: wdata = ($urandom & 32'h101) | (($urandom % 4) << 4);
          2'd1: wdata = $urandom % 10;
          2'd2: wdata = $urandom % 2;
          default: wdata = $urandom;
        endcase
        if (addr == 2'd0 && $urandom % 2 == 0) wdata = wdata | 32'h101;
      end
      cyc();
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule